// File: doc/BRIEF.md
# Multi-Source Trigger Detector

The block turns four possible trigger sources into one registered trigger strobe. Two of the sources are external pins that arrive asynchronously. The other two are internal, same-clock trigger lines: one comes from a converter capture path and one from a logic-capture path. A 20-bit configuration word, held steady by the surrounding logic, controls the block. It chooses how each external pin is matched and which sources may fire the output. The output is used to start or stop a sample transfer.

Each external pin first passes through a two-stage synchronizer. The pin then meets a match condition, which is the OR of up to five modes selected for that pin: level low, level high, any edge, rising edge and falling edge. Edges are found by comparing the synchronized value with its value one cycle earlier. The output is the OR of every enabled source's condition, taken through one register. The block has no data stream. All pins are plain control lines with no handshake or back-pressure.

Top module: `trig_sense`

## Requirements
- R1: While `rst` is high, `trig_o` is 0. Reset clears the synchronizer and history state to 0, so a pin held low across reset produces no edge.
- R2: Word bit 0 (pin 0) and bit 1 (pin 1) select low-level matching. When the pin is enabled, `trig_o` is 1 for every cycle in which the pin value seen three clock edges earlier was 0.
- R3: Word bit 2 (pin 0) and bit 3 (pin 1) select high-level matching. When the pin is enabled, `trig_o` follows the pin value seen three edges earlier.
- R4: Word bit 4 (pin 0) and bit 5 (pin 1) select any-edge matching. Each transition of an enabled pin gives a one-cycle pulse on `trig_o` three edges after the new value is applied.
- R5: Word bit 6 (pin 0) and bit 7 (pin 1) select rising-edge matching. Each 0-to-1 transition gives a one-cycle pulse with the same three-edge latency. Two rising pulses from the same pin never fall in adjacent cycles.
- R6: Word bit 8 (pin 0) and bit 9 (pin 1) select falling-edge matching. Each 1-to-0 transition gives a one-cycle pulse with the same three-edge latency.
- R7: Word bit 16 enables pin 0 and bit 17 enables pin 1. A pin whose enable is 0 has no effect on `trig_o`, whatever its mode bits are. With bits 19:16 all 0, `trig_o` is 0 one edge later.
- R8: Word bit 18 enables `adc_trig` and bit 19 enables `logic_trig`. An enabled internal trigger that is high at a clock edge sets `trig_o` at that edge.
- R9: When several mode bits and sources are set together, `trig_o` is the OR of all enabled sources' conditions. Each pin's condition is the OR of its selected modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_pin | input | 2 | Asynchronous external trigger pins, bit 0 is pin 0 |
| adc_trig | input | 1 | Internal trigger from the converter capture path |
| logic_trig | input | 1 | Internal trigger from the logic-capture path |
| cfg_word | input | 20 | Mode selects (bits 9:0) and source enables (bits 19:16) |
| trig_o | output | 1 | Registered combined trigger |

## Verification
Each of the ten mode bits is first tried alone, with only its own pin enabled. The pins are driven with pseudo-random waveforms that both toggle quickly and hold for several cycles. This separates the level modes from the edge modes, and rising edges from falling ones. It also catches pin and bit swaps. A full sweep of all 1024 mode combinations, each paired with a changing enable set, checks the OR combination. All modes are also set with the pin enables cleared, to show that a disabled pin is ignored. The internal triggers are toggled alone to check their one-edge latency.

// File: rtl/trig_sense_pkg.sv
package trig_sense_pkg;

  typedef enum logic [2:0] {
    MODE_LOW  = 3'd0,
    MODE_HIGH = 3'd1,
    MODE_ANY  = 3'd2,
    MODE_RISE = 3'd3,
    MODE_FALL = 3'd4
  } match_mode_e;

  localparam int MODE_COUNT = 5;

  function automatic int mode_bit(input int mode, input int pin, input int pins);
    return mode * pins + pin;
  endfunction

endpackage

// File: rtl/trig_pin_sync.sv
module trig_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/trig_pin_match.sv
module trig_pin_match
  import trig_sense_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pin_now,
  input  logic [MODE_COUNT-1:0] mode_sel,
  output logic                  hit
);

  logic pin_prev;
  logic lvl_low, lvl_high, edge_any, edge_rise, edge_fall;

  always_ff @(posedge clk) begin
    if (rst) pin_prev <= 1'b0;
    else     pin_prev <= pin_now;
  end

  always_comb begin
    lvl_low   = ~pin_now;
    lvl_high  = pin_now;
    edge_any  = pin_now ^ pin_prev;
    edge_rise = pin_now & ~pin_prev;
    edge_fall = ~pin_now & pin_prev;
    hit = (mode_sel[MODE_LOW]  & lvl_low)
        | (mode_sel[MODE_HIGH] & lvl_high)
        | (mode_sel[MODE_ANY]  & edge_any)
        | (mode_sel[MODE_RISE] & edge_rise)
        | (mode_sel[MODE_FALL] & edge_fall);
  end

  logic only_rise;
  assign only_rise = (mode_sel == (MODE_COUNT'(1) << MODE_RISE));

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (only_rise && hit) |=> (!hit || !$stable(mode_sel))); // R5

endmodule

// File: rtl/trig_sense.sv
module trig_sense
  import trig_sense_pkg::*;
#(
  parameter int PIN_COUNT   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ENABLE_BASE = 16,
  localparam int MODE_BITS  = MODE_COUNT * PIN_COUNT,
  localparam int SRC_COUNT  = PIN_COUNT + 2,
  localparam int CFG_W      = ENABLE_BASE + SRC_COUNT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PIN_COUNT-1:0] ext_pin,
  input  logic                 adc_trig,
  input  logic                 logic_trig,
  input  logic [CFG_W-1:0]     cfg_word,
  output logic                 trig_o
);

  localparam int ADC_EN_BIT   = ENABLE_BASE + PIN_COUNT;
  localparam int LOGIC_EN_BIT = ENABLE_BASE + PIN_COUNT + 1;

  logic [PIN_COUNT-1:0] pin_sync;
  logic [PIN_COUNT-1:0] pin_hit;
  logic [SRC_COUNT-1:0] src_cond;
  logic [SRC_COUNT-1:0] src_en;
  logic                 trig_q;

  trig_pin_sync #(
    .WIDTH  (PIN_COUNT),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ext_pin),
    .sync_out (pin_sync)
  );

  genvar p, m;
  generate
    for (p = 0; p < PIN_COUNT; p++) begin : g_pin
      logic [MODE_COUNT-1:0] sel;
      for (m = 0; m < MODE_COUNT; m++) begin : g_sel
        assign sel[m] = cfg_word[mode_bit(m, p, PIN_COUNT)];
      end
      trig_pin_match u_match (
        .clk      (clk),
        .rst      (rst),
        .pin_now  (pin_sync[p]),
        .mode_sel (sel),
        .hit      (pin_hit[p])
      );

      AST_HIGH_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (cfg_word[ENABLE_BASE+p] && cfg_word[mode_bit(MODE_HIGH, p, PIN_COUNT)]
         && pin_sync[p]) |=> trig_o); // R3
    end

    if (ENABLE_BASE > MODE_BITS) begin : g_gap
      logic unused_cfg_gap;
      assign unused_cfg_gap = ^cfg_word[ENABLE_BASE-1:MODE_BITS];
    end
  endgenerate

  assign src_cond = {logic_trig, adc_trig, pin_hit};
  assign src_en   = cfg_word[CFG_W-1:ENABLE_BASE];

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= |(src_cond & src_en);
  end

  assign trig_o = trig_q;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !trig_o); // R1

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (src_en == '0) |=> !trig_o); // R7

  AST_ADC_PASS: assert property (@(posedge clk) disable iff (rst)
    (cfg_word[ADC_EN_BIT] && adc_trig) |=> trig_o); // R8

  AST_LOGIC_PASS: assert property (@(posedge clk) disable iff (rst)
    (cfg_word[LOGIC_EN_BIT] && logic_trig) |=> trig_o); // R8

endmodule

// File: tb/test_trig_sense.sv
module test_trig_sense;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ext_pin = '0;
  logic        adc_trig = 1'b0;
  logic        logic_trig = 1'b0;
  logic [19:0] cfg_word = '0;
  logic        trig_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // history of driven values: index 0 = most recent
  logic [1:0]  pd [4];
  logic        ad0, ld0;
  logic [19:0] cd0;
  logic [15:0] lfsr = 16'hACE1;
  int          cyc = 0;

  always #2 clk = ~clk;

  trig_sense i_trig_sense (
    .clk        (clk),
    .rst        (rst),
    .ext_pin    (ext_pin),
    .adc_trig   (adc_trig),
    .logic_trig (logic_trig),
    .cfg_word   (cfg_word),
    .trig_o     (trig_o)
  );

  function automatic logic model(input logic [19:0] c, input logic [1:0] s,
                                 input logic [1:0] pv, input logic a, input logic l);
    logic e = 1'b0;
    for (int i = 0; i < 2; i++) begin
      logic hit;
      hit = (c[i]   & ~s[i])
          | (c[2+i] &  s[i])
          | (c[4+i] & (s[i] ^ pv[i]))
          | (c[6+i] & (s[i] & ~pv[i]))
          | (c[8+i] & (~s[i] & pv[i]));
      e = e | (c[16+i] & hit);
    end
    e = e | (c[18] & a) | (c[19] & l);
    return e;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d cfg=%h: trig_o=%b expected %b", tag, cyc, cd0, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] pins, input logic a, input logic l,
                      input logic [19:0] c, input string tag);
    logic e;
    @(negedge clk);
    e = model(cd0, pd[2], pd[3], ad0, ld0);
    check(trig_o, e, tag);
    pd[3] = pd[2]; pd[2] = pd[1]; pd[1] = pd[0]; pd[0] = pins;
    ad0 = a; ld0 = l; cd0 = c;
    ext_pin = pins; adc_trig = a; logic_trig = l; cfg_word = c;
    cyc++;
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // pins toggle freely in some windows and hold in others
  task automatic run(input logic [19:0] c, input int n, input string tag);
    logic [1:0] pins;
    pins = pd[0];
    for (int k = 0; k < n; k++) begin
      lfsr = lfsr_next(lfsr);
      if (lfsr[7] | lfsr[3]) pins = lfsr[1:0];
      step(pins, lfsr[5], lfsr[9], c, tag);
    end
  endtask

  initial begin
    string mtag [5] = '{"R2", "R3", "R4", "R5", "R6"};
    for (int i = 0; i < 4; i++) pd[i] = '0;
    ad0 = 0; ld0 = 0; cd0 = '0;

    // R1: everything asserted while in reset, output must stay low
    cfg_word = 20'hF03FF; adc_trig = 1'b1; logic_trig = 1'b1; ext_pin = 2'b00;
    repeat (5) @(posedge clk);
    @(negedge clk); check(trig_o, 1'b0, "R1");
    cfg_word = '0; adc_trig = 1'b0; logic_trig = 1'b0;
    repeat (2) @(negedge clk);
    check(trig_o, 1'b0, "R1");
    rst = 1'b0;
    step(2'b00, 0, 0, '0, "R1");
    step(2'b00, 0, 0, '0, "R1");

    // single mode bit per pin, only that pin enabled
    for (int m = 0; m < 5; m++)
      for (int i = 0; i < 2; i++)
        run(20'(1 << (m*2+i)) | 20'(1 << (16+i)), 60, mtag[m]);

    // R7: all modes set, pin enables off (internal off too, then one pin only)
    run(20'h003FF, 60, "R7");
    run(20'h103FF & ~20'h002AA, 40, "R7");
    run(20'h2000A, 40, "R7");

    // R8: internal triggers alone
    run(20'h40000, 40, "R8");
    run(20'h80000, 40, "R8");
    run(20'hC0000, 40, "R8");

    // R9: sweep all mode combinations with changing enables
    for (int m = 0; m < 1024; m++) begin
      logic [3:0] en;
      en = 4'(m) ^ 4'(m >> 6) ^ 4'(m >> 3);
      run({en, 6'd0, 10'(m)}, 14, "R9");
    end
    for (int e = 0; e < 16; e++) run({4'(e), 6'd0, 10'h3FF}, 20, "R9");

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule